// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits inside a coprocessor and keeps a shadow copy of the host CPU's instruction prefetch queue. Each time the host fetches an instruction byte over the shared bus, the tracker stores that byte and its 20-bit fetch address in a small FIFO. Every clock it also reads a two-bit queue-status code from the host. The code tells it whether the host took a first opcode byte, took a later byte, flushed its queue, or did nothing.

When the host takes a first opcode byte, the tracker checks whether the byte carries the escape prefix that marks a coprocessor instruction. If it does, the next later byte that the host takes is captured as the second opcode byte. The tracker then gives a one-clock match pulse and presents both opcode bytes. It also presents a 32-bit instruction pointer built from the escape byte's address and the eleven opcode bits that are not part of the prefix. Opcodes without the prefix cause no action.

Top module: `esc_queue_tracker`

## Requirements
- R1: After reset, `esc_hit` is 0, `op_first`, `op_second` and `instr_ptr` are all zero, and the shadow queue is empty.
- R2: The shadow queue holds up to 6 entries, each a byte plus its fetch address, in first-in first-out order. A fetch strobe that arrives while the queue is full and no byte is taken in the same cycle is dropped.
- R3: Status code 2'b00 leaves the shadow queue and the pending-escape state unchanged.
- R4: Status code 2'b01 with a non-empty queue removes the head entry. Bits [7:3] of that byte are compared with 5'b11011, and the result becomes the pending-escape flag. The byte and its address are kept for the pointer.
- R5: Status code 2'b10 empties the shadow queue and clears the pending-escape flag. A fetch strobe in that same cycle is dropped. A later 2'b11 code therefore captures nothing.
- R6: Status code 2'b11 with a non-empty queue removes the head entry. If the pending-escape flag is set, that byte is captured as the second opcode byte, `esc_hit` is high for exactly the one following clock cycle, and the flag is cleared. Otherwise the byte is discarded and no pulse occurs.
- R7: On a capture, `instr_ptr` is {escape address[19:0], escape byte[2:0], second byte[7:0], 1'b0}: the address in bits [31:12], the eleven opcode bits in [11:1], and bit 0 is 0.
- R8: `op_first`, `op_second` and `instr_ptr` keep their last captured values until the next capture.
- R9: Status code 2'b01 or 2'b11 with an empty queue has no effect, and the pending-escape flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | Host instruction byte fetch strobe |
| fetch_byte | input | 8 | Fetched instruction byte |
| fetch_addr | input | 20 | Address of the fetched byte |
| q_status | input | 2 | Host queue-status code |
| esc_hit | output | 1 | One-cycle pulse after a second opcode byte is captured |
| op_first | output | 8 | Captured escape (first) opcode byte |
| op_second | output | 8 | Captured second opcode byte |
| instr_ptr | output | 32 | Instruction pointer of the captured escape instruction |

## Verification
Assertions check on every cycle that the queue occupancy never exceeds its depth, and that a flush leaves the queue empty with no pending escape. They also check that the occupancy is unchanged when nothing is pushed or taken, that a full queue stays full when a strobe is dropped, and that the match pulse lasts one cycle and only follows a later-byte code. The FIFO ordering, the stored addresses, the prefix comparison and the pointer bit layout can only be shown by the bench. The bench runs a reference queue model over directed and random status and fetch sequences to show these, together with the dropped pushes on a full queue and the pending flag surviving a take from an empty queue.

// File: rtl/esc_queue_pkg.sv
// Package: shared widths, status codes and the queue entry type for the
// coprocessor instruction queue tracker.
package esc_queue_pkg;
    localparam int ADDR_W = 20;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 32;
    localparam logic [4:0] ESC_PREFIX = 5'b11011;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } qent_t;
endpackage

// File: rtl/shadow_fifo.sv
// shadow_fifo: circular FIFO of instruction bytes with their fetch addresses.
// Assumes: pop is raised only when the caller wants the head removed; a pop on
// an empty queue is ignored. Flush wins over push and pop in the same cycle.
module shadow_fifo
    import esc_queue_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  push,
    input  qent_t push_ent,
    input  logic  pop,
    output qent_t head_ent,
    output logic  head_vld
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    qent_t          mem [DEPTH];
    logic [PW-1:0]  rd_idx, wr_idx;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    // Accept a push when there is room or a byte leaves in the same cycle.
    always_comb begin
        do_pop   = pop && (count != '0) && !flush;
        do_push  = push && !flush && ((count != FULL_CNT) || do_pop);
        head_vld = (count != '0);
        head_ent = mem[rd_idx];
    end

    // Storage write; entries need no reset because count gates their use.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_idx] <= push_ent;
        end
    end

    // Index and occupancy bookkeeping with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_idx <= '0;
            wr_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (do_pop) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop && !flush) |=> count == FULL_CNT);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !flush) |=> $stable(count));

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/esc_matcher.sv
// esc_matcher: follows the host queue-status code, decides when the queue
// head is taken, detects the escape prefix on a first byte and captures the
// following byte together with the instruction pointer.
// Assumes: head_ent is valid whenever head_vld is high.
module esc_matcher
    import esc_queue_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        q_status,
    input  logic              head_vld,
    input  qent_t             head_ent,
    output logic              pop,
    output logic              flush,
    output logic              esc_hit,
    output logic [BYTE_W-1:0] op_first,
    output logic [BYTE_W-1:0] op_second,
    output logic [PTR_W-1:0]  instr_ptr
);
    qstat_e            qs;
    logic              pending;
    logic [ADDR_W-1:0] pend_addr;
    logic [BYTE_W-1:0] pend_byte;

    // Decode the status code into queue commands.
    always_comb begin
        qs    = qstat_e'(q_status);
        flush = (qs == QS_FLUSH);
        pop   = head_vld && ((qs == QS_FIRST) || (qs == QS_NEXT));
    end

    // Pending-escape tracking, capture and the one-cycle match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            pend_addr <= '0;
            pend_byte <= '0;
            esc_hit   <= 1'b0;
            op_first  <= '0;
            op_second <= '0;
            instr_ptr <= '0;
        end else begin
            esc_hit <= 1'b0;
            unique case (qs)
                QS_FLUSH: pending <= 1'b0;
                QS_FIRST: begin
                    if (head_vld) begin
                        pending   <= (head_ent.data[7:3] == ESC_PREFIX);
                        pend_addr <= head_ent.addr;
                        pend_byte <= head_ent.data;
                    end
                end
                QS_NEXT: begin
                    if (head_vld && pending) begin
                        pending   <= 1'b0;
                        esc_hit   <= 1'b1;
                        op_first  <= pend_byte;
                        op_second <= head_ent.data;
                        instr_ptr <= {pend_addr, pend_byte[2:0], head_ent.data, 1'b0};
                    end
                end
                default: pending <= pending;
            endcase
        end
    end

    assert_pulse_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        esc_hit |=> !esc_hit);

    assert_hit_after_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(esc_hit) |-> $past(q_status) == 2'b11);

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status == 2'b10) |=> !pending);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_status != 2'b11) |=> ($stable(instr_ptr) && $stable(op_second)));
endmodule

// File: rtl/esc_queue_tracker.sv
// esc_queue_tracker: top level. Shadows the host prefetch queue from snooped
// fetches and the host's queue-status code, and reports escape instructions.
// Assumes: one fetch strobe and one status code per clock at most.
module esc_queue_tracker
    import esc_queue_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_vld,
    input  logic [7:0]  fetch_byte,
    input  logic [19:0] fetch_addr,
    input  logic [1:0]  q_status,
    output logic        esc_hit,
    output logic [7:0]  op_first,
    output logic [7:0]  op_second,
    output logic [31:0] instr_ptr
);
    qent_t push_ent, head_ent;
    logic  head_vld, pop, flush;

    // Pack the snooped fetch into a queue entry.
    always_comb begin
        push_ent.addr = fetch_addr;
        push_ent.data = fetch_byte;
    end

    shadow_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (fetch_vld),
        .push_ent (push_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .head_vld (head_vld)
    );

    esc_matcher match_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_status  (q_status),
        .head_vld  (head_vld),
        .head_ent  (head_ent),
        .pop       (pop),
        .flush     (flush),
        .esc_hit   (esc_hit),
        .op_first  (op_first),
        .op_second (op_second),
        .instr_ptr (instr_ptr)
    );
endmodule

// File: tb/esc_queue_tracker_tb_top.sv
module esc_queue_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [7:0]  fetch_byte = '0;
    logic [19:0] fetch_addr = '0;
    logic [1:0]  q_status = 2'b00;
    logic        esc_hit;
    logic [7:0]  op_first, op_second;
    logic [31:0] instr_ptr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    esc_queue_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_byte(fetch_byte),
        .fetch_addr(fetch_addr), .q_status(q_status), .esc_hit(esc_hit),
        .op_first(op_first), .op_second(op_second), .instr_ptr(instr_ptr)
    );

    // Reference model state, built from the requirements.
    logic [27:0] mq[$];
    bit          m_pend;
    logic [19:0] m_paddr;
    logic [7:0]  m_pbyte;
    bit          e_hit;
    logic [7:0]  e_first, e_second;
    logic [31:0] e_ptr;
    int          hits_seen = 0;

    function automatic logic [31:0] make_ptr(logic [19:0] a, logic [7:0] b0, logic [7:0] b1);
        return {a, b0[2:0], b1, 1'b0};
    endfunction

    function automatic bit is_esc(logic [7:0] b);
        return b[7:3] == 5'b11011;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance the model by one clock with the given inputs.
    task automatic model_step(bit vld, logic [7:0] b, logic [19:0] a, logic [1:0] qs);
        bit popped = 0;
        logic [27:0] e;
        e_hit = 0;
        if (qs == 2'b10) begin
            mq.delete();
            m_pend = 0;
        end else begin
            if (qs == 2'b01 && mq.size() > 0) begin
                e = mq.pop_front();
                popped = 1;
                m_pend  = is_esc(e[7:0]);
                m_paddr = e[27:8];
                m_pbyte = e[7:0];
            end else if (qs == 2'b11 && mq.size() > 0) begin
                e = mq.pop_front();
                popped = 1;
                if (m_pend) begin
                    e_hit    = 1;
                    e_first  = m_pbyte;
                    e_second = e[7:0];
                    e_ptr    = make_ptr(m_paddr, m_pbyte, e[7:0]);
                    m_pend   = 0;
                end
            end
            if (vld && mq.size() < 6) mq.push_back({a, b});
            if (popped) begin end
        end
    endtask

    // Drive one cycle, then compare the outputs after the edge.
    task automatic step(string tag, bit vld, logic [7:0] b, logic [19:0] a, logic [1:0] qs);
        @(negedge clk);
        fetch_vld  = vld;
        fetch_byte = b;
        fetch_addr = a;
        q_status   = qs;
        @(posedge clk);
        model_step(vld, b, a, qs);
        #1;
        check(tag, "esc_hit", {31'b0, esc_hit}, {31'b0, e_hit});
        if (e_hit) hits_seen++;
        check(tag, "instr_ptr", instr_ptr, e_ptr);
        check(tag, "op_bytes", {16'b0, op_first, op_second}, {16'b0, e_first, e_second});
    endtask

    task automatic push(string tag, logic [7:0] b, logic [19:0] a);
        step(tag, 1, b, a, 2'b00);
    endtask

    task automatic qcode(string tag, logic [1:0] qs);
        step(tag, 0, 8'h00, 20'h0, qs);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int h0;
        void'($urandom(32'd20240611));
        m_pend = 0; m_paddr = '0; m_pbyte = '0;
        e_hit = 0; e_first = '0; e_second = '0; e_ptr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "esc_hit", {31'b0, esc_hit}, 32'd0);
        check("R1", "instr_ptr", instr_ptr, 32'd0);
        check("R1", "op_bytes", {16'b0, op_first, op_second}, 32'd0);

        // R4 R6 R7: escape byte then second byte gives a capture
        push("R4", 8'hD9, 20'h12345);
        push("R4", 8'hA7, 20'h12346);
        qcode("R4", 2'b01);
        qcode("R6", 2'b11);
        check("R7", "ptr_layout", instr_ptr, {20'h12345, 3'b001, 8'hA7, 1'b0});
        qcode("R6", 2'b00);
        check("R6", "pulse_width", {31'b0, esc_hit}, 32'd0);

        // R6: non-escape first byte, no capture; R8: outputs hold
        push("R6", 8'h45, 20'h00100);
        push("R6", 8'h99, 20'h00101);
        qcode("R6", 2'b01);
        qcode("R8", 2'b11);
        check("R8", "held_ptr", instr_ptr, {20'h12345, 3'b001, 8'hA7, 1'b0});

        // R5: flush clears queue and pending flag, same-cycle push dropped
        push("R5", 8'hD8, 20'h00200);
        push("R5", 8'h11, 20'h00201);
        qcode("R5", 2'b01);
        step("R5", 1, 8'h66, 20'h00202, 2'b10);
        push("R5", 8'h22, 20'h00203);
        qcode("R5", 2'b11);
        check("R5", "no_capture_after_flush", {31'b0, esc_hit}, 32'd0);
        qcode("R5", 2'b10);

        // R2: fill past depth; the 7th (escape) and 8th pushes are dropped
        for (int i = 0; i < 6; i++) push("R2", 8'(i + 1), 20'(16'h300 + i));
        push("R2", 8'hD8, 20'h00306);
        push("R2", 8'h33, 20'h00307);
        h0 = hits_seen;
        for (int i = 0; i < 4; i++) begin
            qcode("R2", 2'b01);
            qcode("R2", 2'b11);
        end
        check("R2", "dropped_escape", 32'(hits_seen - h0), 32'd0);
        push("R2", 8'hDE, 20'h00400);
        push("R2", 8'h3C, 20'h00401);
        qcode("R2", 2'b01);
        qcode("R2", 2'b11);
        check("R2", "fifo_order_ptr", instr_ptr, {20'h00400, 3'b110, 8'h3C, 1'b0});

        // R3: idle codes leave queue and pending flag alone
        push("R3", 8'hDB, 20'h00500);
        push("R3", 8'h55, 20'h00501);
        qcode("R3", 2'b01);
        for (int i = 0; i < 3; i++) qcode("R3", 2'b00);
        qcode("R3", 2'b11);
        check("R3", "capture_after_idle", {24'b0, op_second}, 32'h55);

        // R9: take from empty queue keeps the pending flag
        qcode("R9", 2'b10);
        push("R9", 8'hDF, 20'h00600);
        qcode("R9", 2'b01);
        qcode("R9", 2'b11);
        qcode("R9", 2'b01);
        push("R9", 8'h77, 20'h00601);
        qcode("R9", 2'b11);
        check("R9", "pending_survives", {24'b0, op_second}, 32'h77);

        // Random phase: mixed fetches and status codes against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] b;
            logic [1:0] qs;
            int r;
            r  = $urandom % 16;
            qs = (r < 5) ? 2'b00 : (r < 10) ? 2'b01 : (r < 15) ? 2'b11 : 2'b10;
            b  = ($urandom % 3 == 0) ? {5'b11011, 3'($urandom)} : 8'($urandom);
            step("R2_R4_R6_R7", ($urandom % 2) == 1, b, 20'($urandom), qs);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule